// File: doc/BRIEF.md
# Supply Startup and Restart Sequencer

This block sequences the supply rail of a controller that powers itself from its own switching output. A high-voltage current source charges the supply capacitor at power-up. Once the rail is high enough, the source is shut off and the power stage is allowed to switch. From then on the rail is either kept up by an auxiliary winding, or topped up by the source whenever it sags, or sent back to a full recharge when it collapses. The block sees the rail only through three digital comparator flags and one combined fault flag. It drives two enables: one for the startup current source and one that permits switching.

Every flag passes through a two-flop synchronizer before the state machine sees it. The state machine has five states. A cold or lockout recharge keeps the source on and holds switching off. In normal run, switching is allowed and the source is off. In restart, switching carries on while the rail drains toward lockout. A fault hold keeps both enables off while the rail drains. A fault top-up turns the source on while switching stays blocked. The current state leaves the block as a three-bit code for test.

Top module: `supply_seq_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is CHARGE. The state code is 0, `src_en_o` is 1 and `sw_en_o` is 0.
- R2: In CHARGE the block stays put until the turn-on flag is seen. The minimum-level flag and the lockout flag have no effect there.
- R3: When the turn-on flag is seen in CHARGE or REFILL with no fault, the block moves to RUN. The state code is 1, the source is off and switching is on.
- R4: When the turn-on flag is seen in CHARGE or REFILL while a fault is present, the block moves to HOLD. The state code is 3, and both the source and switching are off.
- R5: In RUN with no fault, the minimum-level flag moves the block to RESTART. The state code is 2, switching stays on and the source stays off.
- R6: In RESTART with no fault, the lockout flag moves the block to CHARGE. Switching stops and the source turns on.
- R7: In RESTART the block ignores the minimum-level flag clearing. It stays in RESTART until lockout or a fault.
- R8: In HOLD, the minimum-level flag moves the block to REFILL. The state code is 4, the source is on and switching is off. In REFILL the block waits for the turn-on flag.
- R9: In HOLD, when the fault clears and the minimum-level flag is not set, the block returns to RUN.
- R10: A fault takes priority over the rail flags in the same cycle. In RUN, a fault moves the block to HOLD even if the minimum-level flag is also set. In RESTART, a fault moves the block to REFILL even if the lockout flag is also set.
- R11: An input change that is stable from one falling edge onward reaches the state and enables after the third following rising edge. The outputs do not change after the second.
- R12: The source enable and the switching enable are never both 1. The state code is always in the range 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_on_i | input | 1 | Rail at or above the turn-on level |
| rail_low_i | input | 1 | Rail below the minimum operating level |
| rail_lock_i | input | 1 | Rail below the lockout level |
| fault_i | input | 1 | Combined line-under, line-over and thermal fault |
| src_en_o | output | 1 | Enables the startup current source |
| sw_en_o | output | 1 | Permits power switching |
| state_o | output | 3 | State code: 0 CHARGE, 1 RUN, 2 RESTART, 3 HOLD, 4 REFILL |

## Verification
A fault and a rail flag can reach the state machine in the same cycle. The fault and the minimum-level flag can arrive together in RUN. The fault and the lockout flag can arrive together in RESTART. The bench provokes both cases by changing the two inputs on the same falling edge, so that they pass through the synchronizers side by side. It then checks that the fault path wins: HOLD in the first case and REFILL in the second, never RESTART or CHARGE. A third check covers a fault that clears in HOLD at the moment the minimum-level flag sets. Here the top-up must win over a return to RUN.

// File: rtl/supply_seq_pkg.sv
// Shared types for the supply startup and restart sequencer.
// Assumes a three-bit state code is visible at the block edge.
package supply_seq_pkg;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_CHARGE  = 3'd0,
        ST_RUN     = 3'd1,
        ST_RESTART = 3'd2,
        ST_HOLD    = 3'd3,
        ST_REFILL  = 3'd4
    } seq_state_t;

    // Bit positions of the flag vector that is fed through the synchronizer
    localparam int F_ON    = 0;
    localparam int F_LOW   = 1;
    localparam int F_LOCK  = 2;
    localparam int F_FAULT = 3;
    localparam int NFLAGS  = 4;

endpackage

// File: rtl/seq_flag_sync.sv
// Multi-stage synchronizer for a vector of slow level flags.
// Assumes each flag is a level that holds for several clocks, so that
// per-bit resolution is enough and no bus coherence is required.
module seq_flag_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw flags
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Shift the flags one stage further
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/seq_fsm.sv
// Supply sequencing state machine.
// Assumes the rail flags are already synchronized. A fault outranks
// every rail flag. Reset returns the machine to the cold-charge state.
module seq_fsm
    import supply_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       on_s,
    input  logic       low_s,
    input  logic       lock_s,
    input  logic       fault_s,
    output seq_state_t state_q
);

    seq_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHARGE: begin
                if (on_s) state_d = fault_s ? ST_HOLD : ST_RUN;
            end
            ST_RUN: begin
                if (fault_s)    state_d = ST_HOLD;
                else if (low_s) state_d = ST_RESTART;
            end
            ST_RESTART: begin
                if (fault_s)     state_d = ST_REFILL;
                else if (lock_s) state_d = ST_CHARGE;
            end
            ST_HOLD: begin
                if (low_s)         state_d = ST_REFILL;
                else if (!fault_s) state_d = ST_RUN;
            end
            ST_REFILL: begin
                if (on_s) state_d = fault_s ? ST_HOLD : ST_RUN;
            end
            default: state_d = ST_CHARGE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CHARGE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/seq_out_dec.sv
// Turns the sequencer state into the two enables and the test code.
// Assumes the state is registered, so the outputs are glitch-free decodes.
module seq_out_dec
    import supply_seq_pkg::*;
(
    input  seq_state_t      state_q,
    output logic            src_en,
    output logic            sw_en,
    output logic [ST_W-1:0] code
);

    // Map each state onto the source and switching enables
    always_comb begin
        src_en = 1'b0;
        sw_en  = 1'b0;
        unique case (state_q)
            ST_CHARGE, ST_REFILL: src_en = 1'b1;
            ST_RUN, ST_RESTART:   sw_en  = 1'b1;
            default: ;
        endcase
    end

    assign code = state_q;

endmodule

// File: rtl/supply_seq_top.sv
// Top of the supply startup and restart sequencer.
// Assumes the comparator flags and the fault flag are asynchronous levels.
// Assumes the hysteresis that keeps those levels stable sits outside.
module supply_seq_top
    import supply_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rail_on_i,
    input  logic            rail_low_i,
    input  logic            rail_lock_i,
    input  logic            fault_i,
    output logic            src_en_o,
    output logic            sw_en_o,
    output logic [ST_W-1:0] state_o
);

    logic [NFLAGS-1:0] raw_flags;
    logic [NFLAGS-1:0] syn_flags;
    logic              on_s, low_s, lock_s, fault_s;
    seq_state_t        state_q;

    // Gather the flags into one vector for the synchronizer
    always_comb begin
        raw_flags          = '0;
        raw_flags[F_ON]    = rail_on_i;
        raw_flags[F_LOW]   = rail_low_i;
        raw_flags[F_LOCK]  = rail_lock_i;
        raw_flags[F_FAULT] = fault_i;
    end

    seq_flag_sync #(
        .WIDTH   (NFLAGS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (syn_flags)
    );

    assign on_s    = syn_flags[F_ON];
    assign low_s   = syn_flags[F_LOW];
    assign lock_s  = syn_flags[F_LOCK];
    assign fault_s = syn_flags[F_FAULT];

    seq_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_s    (on_s),
        .low_s   (low_s),
        .lock_s  (lock_s),
        .fault_s (fault_s),
        .state_q (state_q)
    );

    seq_out_dec dec_i (
        .state_q (state_q),
        .src_en  (src_en_o),
        .sw_en   (sw_en_o),
        .code    (state_o)
    );

endmodule

// File: rtl/supply_seq_chk.sv
// Property checker for the supply sequencer. It is bound to the top
// module and reads its synchronized flags.
module supply_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       on_s,
    input logic       low_s,
    input logic       lock_s,
    input logic       fault_s,
    input logic       src_en_o,
    input logic       sw_en_o,
    input logic [2:0] state_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (state_o == 3'd0 && src_en_o && !sw_en_o));

    // R2
    charge_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !on_s) |=> (state_o == 3'd0));

    // R5
    restart_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && low_s && !fault_s) |=> (state_o == 3'd2 && sw_en_o));

    // R6
    lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && lock_s && !fault_s) |=> (state_o == 3'd0 && src_en_o));

    // R10
    fault_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && fault_s) |=> (state_o == 3'd3 && !sw_en_o));

    // R12
    excl_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_en_o && sw_en_o));

    // R12
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

endmodule

bind supply_seq_top supply_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .on_s     (on_s),
    .low_s    (low_s),
    .lock_s   (lock_s),
    .fault_s  (fault_s),
    .src_en_o (src_en_o),
    .sw_en_o  (sw_en_o),
    .state_o  (state_o)
);

// File: tb/supply_seq_top_tb_top.sv
// Scoreboard bench for the supply sequencer.
module supply_seq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       on_i = 1'b0, low_i = 1'b1, lock_i = 1'b1, flt_i = 1'b0;
    logic       src_en, sw_en;
    logic [2:0] state;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [2:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    supply_seq_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rail_on_i   (on_i),
        .rail_low_i  (low_i),
        .rail_lock_i (lock_i),
        .fault_i     (flt_i),
        .src_en_o    (src_en),
        .sw_en_o     (sw_en),
        .state_o     (state)
    );

    // Enables expected for each state code, taken from the requirements
    function automatic logic exp_src(input logic [2:0] s);
        return (s == 3'd0 || s == 3'd4);
    endfunction
    function automatic logic exp_sw(input logic [2:0] s);
        return (s == 3'd1 || s == 3'd2);
    endfunction

    // Driver: apply flags {fault,lock,low,on} at a falling edge, wait, push expectation
    task automatic step(input logic [3:0] f, input int waits,
                        input logic [2:0] exp, input string tag);
        flt_i  = f[3];
        lock_i = f[2];
        low_i  = f[1];
        on_i   = f[0];
        repeat (waits) @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare just after each falling edge
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            logic [2:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (state !== e || src_en !== exp_src(e) || sw_en !== exp_sw(e)) begin
                n_fails++;
                $display("FAIL %s: state=%0d src=%0b sw=%0b expected state=%0d src=%0b sw=%0b",
                         t, state, src_en, sw_en, e, exp_src(e), exp_sw(e));
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        step(4'b0110, 0, 3'd0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R2: low and lock flags ignored while charging
        step(4'b0110, 4, 3'd0, "R2 charge hold");
        step(4'b0010, 4, 3'd0, "R2 lock ignored");
        // R11: not visible after two edges, visible after three
        step(4'b0001, 2, 3'd0, "R11 latency early");
        step(4'b0001, 1, 3'd1, "R11 latency / R3 run");
        // R5: below minimum while switching
        step(4'b0010, 3, 3'd2, "R5 restart");
        // R7: recovery above minimum ignored in restart
        step(4'b0000, 4, 3'd2, "R7 restart kept");
        // R6: lockout
        step(4'b0110, 3, 3'd0, "R6 lockout recharge");
        step(4'b0001, 3, 3'd1, "R3 run after recharge");
        // R4-style fault in run goes to hold
        step(4'b1001, 3, 3'd3, "R10 fault in run");
        // R8: top-up in fault
        step(4'b1010, 3, 3'd4, "R8 refill");
        step(4'b1001, 3, 3'd3, "R4 refill to hold with fault");
        // R9: fault clears
        step(4'b0001, 3, 3'd1, "R9 fault cleared");
        // R10: fault and minimum flag together in run
        step(4'b1010, 3, 3'd3, "R10 fault beats low");
        step(4'b1010, 1, 3'd4, "R8 hold to refill");
        step(4'b0001, 3, 3'd1, "R3 refill to run");
        step(4'b0010, 3, 3'd2, "R5 restart again");
        // R10: fault and lockout together in restart
        step(4'b1110, 3, 3'd4, "R10 fault beats lock");
        step(4'b1001, 3, 3'd3, "R4 on with fault");
        // Fault clears while minimum flag sets in hold: top-up wins (R8)
        step(4'b0010, 3, 3'd4, "R8 low beats fault clear");
        step(4'b0001, 3, 3'd1, "R3 run");
        // R1: reset from run
        rst_n = 1'b0;
        step(4'b1001, 1, 3'd0, "R1 reset from run");
        @(negedge clk);
        rst_n = 1'b1;
        // R4: turn-on with fault from cold charge
        step(4'b1001, 3, 3'd3, "R4 cold start with fault");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule